// File: doc/BRIEF.md
# Dual Comparator Control with Change Interrupt

This block is the digital side of a pair of analog comparators. Each channel has an eight-bit control and status register. Software writes it to turn the channel on, to choose the positive and negative inputs, and to route the result to an output pin. Software reads it back to get the settled comparator state and a sticky change flag. The analog decision is modelled digitally. Each candidate input arrives as a VW-bit level code: two positive candidates per channel, a shared external reference and a shared internal reference. The comparator result is formed from these codes without any clock, as the analog part would produce it.

The raw result goes straight to the channel's pin, with no clock in the path. A copy passes through a two-stage synchronizer before software can see it. When a channel is switched on, a settling counter of SETTLE_CYC clock cycles holds back the visible status and the flag. This stops the first, unsettled output from being reported. Every change of the visible status after settling sets the sticky flag. The flag raises an interrupt request when both the per-channel enable and the global enable allow it. Switching a channel off returns its status and flag to zero.

Top module: `cmp_ctrl_top`

## Requirements
- R1: Register fields per channel: bit 5 enable, bit 4 positive select, bit 3 negative select, bit 2 pin enable, bit 1 status (read-only), bit 0 change flag. Bits 7:6 always read 0. All bits are 0 after reset. A write with wr_en[i] high loads bits 5:2 into the register on the next clock edge.
- R2: Positive select 0 picks input A and 1 picks input B. Negative select 0 picks the external reference and 1 picks the internal reference.
- R3: The raw result is 1 only when the selected positive level is strictly greater than the selected negative level, and only while the channel is enabled. Equal levels give 0.
- R4: The status bit follows the raw result through two flip-flops and then updates on the next edge. It is 0 from the same clock edge that disables the channel.
- R5: The flag is set on every edge where the settled channel loads a status value that differs from the current one. A set in the same cycle as a clearing write wins.
- R6: Writing 0 to bit 0 clears the flag. Writing 1 to bit 0 leaves the flag unchanged. The flag is 0 whenever the channel is disabled.
- R7: cmp_pin[i] equals the raw result ANDed with the pin enable and the enable. It is combinational, with no clock in the path.
- R8: irq[i] equals flag AND irq_en[i] AND glb_irq_en.
- R9: After the clock edge that enables a channel, status and flag stay 0 for SETTLE_CYC further edges, whatever the inputs do. The first status update happens on the edge after that.
- R10: Each channel's register, status, flag, pin and interrupt depend only on its own write strobe, its own inputs and the shared references.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | N_CMP | Per-channel register write strobe |
| wr_data | input | 8 | Register write data |
| in_a | input | N_CMP*VW | Positive candidate A level per channel |
| in_b | input | N_CMP*VW | Positive candidate B level per channel |
| ref_ext | input | VW | External reference level |
| ref_int | input | VW | Internal reference level |
| irq_en | input | N_CMP | Per-channel interrupt enable |
| glb_irq_en | input | 1 | Global interrupt enable |
| rd_data | output | N_CMP*8 | Register read value per channel |
| cmp_pin | output | N_CMP | Unsynchronized comparator pin output |
| irq | output | N_CMP | Interrupt request per channel |

## Verification
The bench targets the following corner cases:
- Input changes during the settling window. A design that counted one cycle too few or too many would expose status one edge early or late.
- Equal positive and negative levels. A design using greater-or-equal would report 1.
- A flag write of 1. A design that loaded bit 0 as written would set the flag from software.
- Disabling while the flag is set. A design that only gated the read value would leave a stale flag that fires an interrupt when the channel is re-enabled.
- The pin is checked in the same cycle as the enable and input changes. This catches a pin path that was wrongly synchronized.
- The second channel is checked throughout. This catches crossed per-channel wiring.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int B_EN   = 5;
  localparam int B_PSEL = 4;
  localparam int B_NSEL = 3;
  localparam int B_OE   = 2;
  localparam int B_STAT = 1;
  localparam int B_FLAG = 0;

  typedef struct packed {
    logic en;
    logic psel;
    logic nsel;
    logic oe;
  } cmp_cfg_t;
endpackage

// File: rtl/cmp_inmux.sv
module cmp_inmux #(
  parameter int VW = 8
) (
  input  logic [VW-1:0] in_a,
  input  logic [VW-1:0] in_b,
  input  logic [VW-1:0] ref_ext,
  input  logic [VW-1:0] ref_int,
  input  logic          psel,
  input  logic          nsel,
  input  logic          en,
  output logic          raw
);
  logic [VW-1:0] pos_lvl;
  logic [VW-1:0] neg_lvl;

  always_comb begin
    pos_lvl = psel ? in_b : in_a;
    neg_lvl = nsel ? ref_int : ref_ext;
    raw     = en & (pos_lvl > neg_lvl);
  end
endmodule

// File: rtl/cmp_sync2.sv
module cmp_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/cmp_settle.sv
module cmp_settle #(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_cur,
  input  logic en_nxt,
  output logic ready
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_nxt)
      cnt_d = '0;
    else if (!en_cur)
      cnt_d = CW'(SETTLE_CYC);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ready = en_cur & (cnt_q == '0);
endmodule

// File: rtl/cmp_chan.sv
module cmp_chan
  import cmp_pkg::*;
#(
  parameter int VW         = 8,
  parameter int SETTLE_CYC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [7:0]    wr_data,
  input  logic [VW-1:0] in_a,
  input  logic [VW-1:0] in_b,
  input  logic [VW-1:0] ref_ext,
  input  logic [VW-1:0] ref_int,
  input  logic          irq_en,
  input  logic          glb_irq_en,
  output logic [7:0]    rd,
  output logic          pin,
  output logic          irq
);
  cmp_cfg_t cfg_q;
  cmp_cfg_t cfg_d;
  logic     stat_q, stat_d;
  logic     flag_q, flag_d;
  logic     raw;
  logic     synced;
  logic     ready;

  always_comb begin
    cfg_d = cfg_q;
    if (wr) begin
      cfg_d.en   = wr_data[B_EN];
      cfg_d.psel = wr_data[B_PSEL];
      cfg_d.nsel = wr_data[B_NSEL];
      cfg_d.oe   = wr_data[B_OE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (wr) cfg_q <= cfg_d;
  end

  cmp_inmux #(.VW(VW)) u_mux (
    .in_a(in_a), .in_b(in_b), .ref_ext(ref_ext), .ref_int(ref_int),
    .psel(cfg_q.psel), .nsel(cfg_q.nsel), .en(cfg_q.en), .raw(raw)
  );

  cmp_sync2 u_sync (.clk(clk), .rst_n(rst_n), .d(raw), .q(synced));

  cmp_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .en_cur(cfg_q.en), .en_nxt(cfg_d.en),
    .ready(ready)
  );

  always_comb begin
    stat_d = stat_q;
    flag_d = flag_q;
    if (!cfg_d.en) begin
      stat_d = 1'b0;
      flag_d = 1'b0;
    end else begin
      if (ready) stat_d = synced;
      if (ready && (synced != stat_q))
        flag_d = 1'b1;
      else if (wr && !wr_data[B_FLAG])
        flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rd         = '0;
    rd[B_EN]   = cfg_q.en;
    rd[B_PSEL] = cfg_q.psel;
    rd[B_NSEL] = cfg_q.nsel;
    rd[B_OE]   = cfg_q.oe;
    rd[B_STAT] = stat_q;
    rd[B_FLAG] = flag_q;
  end

  assign pin = raw & cfg_q.oe & cfg_q.en;
  assign irq = flag_q & irq_en & glb_irq_en;
endmodule

// File: rtl/cmp_ctrl_top.sv
module cmp_ctrl_top #(
  parameter int N_CMP      = 2,
  parameter int VW         = 8,
  parameter int SETTLE_CYC = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_CMP-1:0]    wr_en,
  input  logic [7:0]          wr_data,
  input  logic [N_CMP*VW-1:0] in_a,
  input  logic [N_CMP*VW-1:0] in_b,
  input  logic [VW-1:0]       ref_ext,
  input  logic [VW-1:0]       ref_int,
  input  logic [N_CMP-1:0]    irq_en,
  input  logic                glb_irq_en,
  output logic [N_CMP*8-1:0]  rd_data,
  output logic [N_CMP-1:0]    cmp_pin,
  output logic [N_CMP-1:0]    irq
);
  for (genvar i = 0; i < N_CMP; i++) begin : g_ch
    cmp_chan #(.VW(VW), .SETTLE_CYC(SETTLE_CYC)) u_ch (
      .clk(clk), .rst_n(rst_n), .wr(wr_en[i]), .wr_data(wr_data),
      .in_a(in_a[i*VW +: VW]), .in_b(in_b[i*VW +: VW]),
      .ref_ext(ref_ext), .ref_int(ref_int),
      .irq_en(irq_en[i]), .glb_irq_en(glb_irq_en),
      .rd(rd_data[i*8 +: 8]), .pin(cmp_pin[i]), .irq(irq[i])
    );
  end
endmodule

// File: rtl/cmp_ctrl_chk.sv
module cmp_ctrl_chk #(
  parameter int N_CMP = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_CMP*8-1:0] rd_data,
  input logic [N_CMP-1:0]   cmp_pin,
  input logic [N_CMP-1:0]   irq,
  input logic [N_CMP-1:0]   irq_en,
  input logic               glb_irq_en
);
  for (genvar i = 0; i < N_CMP; i++) begin : g_chk
    AST_DIS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[i*8+5] |-> !rd_data[i*8+1]);  // R4
    AST_DIS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[i*8+5] |-> !rd_data[i*8+0]);  // R6
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[i*8+7 -: 2] == 2'b00);  // R1
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] == (rd_data[i*8+0] & irq_en[i] & glb_irq_en));  // R8
    AST_PIN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_pin[i] |-> (rd_data[i*8+5] & rd_data[i*8+2]));  // R7
    AST_FLAG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[i*8+5] && $past(rd_data[i*8+5]) &&
       (rd_data[i*8+1] != $past(rd_data[i*8+1]))) |-> rd_data[i*8+0]);  // R5
    AST_SETTLE_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[i*8+5]) |-> (!rd_data[i*8+1] && !rd_data[i*8+0]));  // R9
  end
endmodule

bind cmp_ctrl_top cmp_ctrl_chk #(.N_CMP(N_CMP)) u_cmp_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .cmp_pin(cmp_pin),
  .irq(irq), .irq_en(irq_en), .glb_irq_en(glb_irq_en)
);

// File: tb/tb_cmp_ctrl_top.sv
module tb_cmp_ctrl_top;
  localparam int N  = 2;
  localparam int VW = 8;
  localparam int ST = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    wr_en;
  logic [7:0]      wr_data;
  logic [N*VW-1:0] in_a, in_b;
  logic [VW-1:0]   ref_ext, ref_int;
  logic [N-1:0]    irq_en;
  logic            glb_irq_en;
  logic [N*8-1:0]  rd_data;
  logic [N-1:0]    cmp_pin, irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  cmp_ctrl_top #(.N_CMP(N), .VW(VW), .SETTLE_CYC(ST)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .in_a(in_a), .in_b(in_b), .ref_ext(ref_ext), .ref_int(ref_int),
    .irq_en(irq_en), .glb_irq_en(glb_irq_en), .rd_data(rd_data),
    .cmp_pin(cmp_pin), .irq(irq)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  bit m_en[N], m_ps[N], m_ns[N], m_oe[N], m_st[N], m_fl[N];
  int m_cnt[N];
  bit sq[N][$];

  function automatic bit m_raw(int i);
    int p, n;
    p = m_ps[i] ? int'(in_b[i*VW +: VW]) : int'(in_a[i*VW +: VW]);
    n = m_ns[i] ? int'(ref_int) : int'(ref_ext);
    return m_en[i] && (p > n);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic void m_reset();
    for (int i = 0; i < N; i++) begin
      m_en[i] = 0; m_ps[i] = 0; m_ns[i] = 0; m_oe[i] = 0;
      m_st[i] = 0; m_fl[i] = 0; m_cnt[i] = 0;
      sq[i] = {1'b0, 1'b0};
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else begin
      for (int i = 0; i < N; i++) begin
        bit raw, rdy, s2, wr, ne;
        raw = m_raw(i);
        rdy = m_en[i] && (m_cnt[i] == 0);
        s2  = sq[i][0];
        wr  = wr_en[i];
        ne  = wr ? wr_data[5] : m_en[i];
        if (!ne) begin
          m_fl[i] = 0; m_st[i] = 0; m_cnt[i] = 0;
        end else begin
          if (rdy && s2 != m_st[i]) m_fl[i] = 1;
          else if (wr && !wr_data[0]) m_fl[i] = 0;
          if (rdy) m_st[i] = s2;
          if (!m_en[i]) m_cnt[i] = ST;
          else if (m_cnt[i] > 0) m_cnt[i]--;
        end
        void'(sq[i].pop_front());
        sq[i].push_back(raw);
        if (wr) begin
          m_en[i] = wr_data[5]; m_ps[i] = wr_data[4];
          m_ns[i] = wr_data[3]; m_oe[i] = wr_data[2];
        end
      end
      #5;
      for (int i = 0; i < N; i++) begin
        logic [7:0] r;
        r = rd_data[i*8 +: 8];
        chk(r[7:2] == {2'b00, m_en[i], m_ps[i], m_ns[i], m_oe[i]}, "R1 fields",
            int'(r[7:2]), int'({2'b00, m_en[i], m_ps[i], m_ns[i], m_oe[i]}));
        chk(r[1] == m_st[i], "R4 status", r[1], m_st[i]);
        chk(r[0] == m_fl[i], "R5 flag", r[0], m_fl[i]);
        chk(cmp_pin[i] == (m_raw(i) && m_oe[i]), "R7 pin", cmp_pin[i],
            m_raw(i) && m_oe[i]);
        chk(irq[i] == (m_fl[i] && irq_en[i] && glb_irq_en), "R8 irq", irq[i],
            m_fl[i] && irq_en[i] && glb_irq_en);
      end
    end
  end

  task automatic wreg(int ch, logic [7:0] d);
    @(negedge clk);
    wr_en = '0; wr_en[ch] = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] rdc(int ch);
    return rd_data[ch*8 +: 8];
  endfunction

  initial begin
    rst_n = 1'b0; wr_en = '0; wr_data = '0; in_a = '0; in_b = '0;
    ref_ext = 8'd50; ref_int = 8'd250; irq_en = '0; glb_irq_en = 1'b0;
    idle(3);
    chk(rd_data == '0 && irq == '0 && cmp_pin == '0, "R1 reset", int'(rd_data), 0);
    rst_n = 1'b1;
    idle(2);
    // R2 R7: A vs external reference, pin immediately valid
    in_a[7:0] = 8'd100;
    wreg(0, 8'h24);
    chk(cmp_pin[0] == 1'b1, "R7 pin immediate", cmp_pin[0], 1);
    chk(rdc(1) == 8'h00, "R10 ch1 untouched", rdc(1), 0);
    // R9: toggle inside the window, status stays 0
    idle(4); in_a[7:0] = 8'd10; idle(3); in_a[7:0] = 8'd100;
    chk(rdc(0)[1:0] == 2'b00, "R9 window masked", rdc(0)[1:0], 0);
    idle(ST);
    chk(rdc(0)[1:0] == 2'b11, "R4 status after settle", rdc(0)[1:0], 3);
    // R8
    irq_en[0] = 1'b1; idle(1);
    chk(irq[0] == 1'b0, "R8 no global", irq[0], 0);
    glb_irq_en = 1'b1; idle(1);
    chk(irq[0] == 1'b1, "R8 irq", irq[0], 1);
    // R6: write 1 keeps flag, write 0 clears
    wreg(0, 8'h25);
    chk(rdc(0)[0] == 1'b1, "R6 write one ignored", rdc(0)[0], 1);
    wreg(0, 8'h24);
    chk(rdc(0)[0] == 1'b0, "R6 clear", rdc(0)[0], 0);
    // R3 equal levels -> 0
    in_a[7:0] = 8'd50; idle(4);
    chk(rdc(0)[1:0] == 2'b01, "R3 equal gives 0", rdc(0)[1:0], 1);
    wreg(0, 8'h24);
    // R2 select B
    in_b[7:0] = 8'd200; wreg(0, 8'h34); idle(4);
    chk(rdc(0)[1] == 1'b1, "R2 B selected", rdc(0)[1], 1);
    // R2 internal reference
    wreg(0, 8'h3C); idle(4);
    chk(rdc(0)[1] == 1'b0, "R2 internal ref", rdc(0)[1], 0);
    // R7 pin enable off
    ref_int = 8'd5; wreg(0, 8'h38); idle(1);
    chk(cmp_pin[0] == 1'b0, "R7 oe off", cmp_pin[0], 0);
    // R10 enable ch1
    in_a[15:8] = 8'd90; wreg(1, 8'h24); idle(ST + 4);
    chk(rdc(1)[1:0] == 2'b11, "R10 ch1 own status", rdc(1)[1:0], 3);
    // R4 R6 disable clears
    wreg(0, 8'h04);
    chk(rdc(0)[1:0] == 2'b00, "R4 disable clears", rdc(0)[1:0], 0);
    wreg(0, 8'h24); idle(ST + 4);
    idle(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule